// File: doc/BRIEF.md
# Paired-Word SHA-2 Message Schedule Generator

This block supplies the message-schedule words to a SHA-2 compression core that retires two rounds per clock. Because the core is unrolled by two, it needs the pair W(2k), W(2k+1) in the same cycle. A per-block mode bit picks the narrow variant, which has 32-bit words and 64 rounds, or the wide variant, which has 64-bit words and 80 rounds.

A block begins with a `start` pulse that also captures the mode. Sixteen message words then arrive one at a time on the load port. Once the last of them is taken, the generator streams one pair per cycle with a valid flag and the index of the even word. The first eight pairs are the loaded words, unchanged. Every later word comes from the feedback recurrence W(t) = σ1(W(t-2)) + W(t-7) + σ0(W(t-15)) + W(t-16), taken modulo the word size. The rotate and shift amounts inside σ0 and σ1 come from a small lookup table that the captured mode indexes.

Top module: `sha2_sched_pair`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle, and `pair_valid` is 0 in the cycle that follows.
- R2: After `start`, each cycle with `in_valid` high takes one word, with W0 first. `pair_valid` stays 0 while words are being loaded. Cycles with `in_valid` low are skipped and add no word.
- R3: The first eight pairs carry the loaded words W0..W15 unchanged. In narrow mode only bits [31:0] of each word are kept.
- R4: When `wide_sel` was 0 at `start`, each word W(t) with t of 16 or more is formed modulo 2^32. Here σ0 = ROTR7 xor ROTR18 xor SHR3 and σ1 = ROTR17 xor ROTR19 xor SHR10, all on 32 bits.
- R5: When `wide_sel` was 1 at `start`, each word W(t) with t of 16 or more is formed modulo 2^64. Here σ0 = ROTR1 xor ROTR8 xor SHR7 and σ1 = ROTR19 xor ROTR61 xor SHR6.
- R6: `pair_valid` rises in the cycle after the 16th word is taken. In each valid cycle `word_even` = W(2k), `word_odd` = W(2k+1) and `pair_base` = 2k, and k goes up by one per cycle with no gap.
- R7: In narrow mode the block outputs exactly 32 pairs and in wide mode exactly 40. `pair_valid` is 0 in the cycle after the last pair.
- R8: While pairs are being output, `in_valid`, `in_word` and `wide_sel` have no effect on the pairs.
- R9: `start` takes priority over everything else, including an `in_valid` in the same cycle. A `start` while pairs are being output abandons the current block and begins a new load.
- R10: In narrow mode, bits [63:32] of `word_even` and `word_odd` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a new block and captures the mode |
| wide_sel | input | 1 | Mode: 1 = 64-bit words and 80 rounds, 0 = 32-bit words and 64 rounds |
| in_valid | input | 1 | A message word is present on `in_word` |
| in_word | input | 64 | Message word; only [31:0] is used in narrow mode |
| pair_valid | output | 1 | `word_even` and `word_odd` hold a schedule pair |
| pair_base | output | 7 | Index 2k of `word_even` |
| word_even | output | 64 | W(2k) |
| word_odd | output | 64 | W(2k+1) |

## Verification
The assertions assume that `start` is a pulse and that a block is not left with fewer than sixteen loaded words while the bench expects output. Within that, the bench may pulse `start` at any time. The bench drives the sixteen words after each `start` and inserts one idle cycle in the middle of every load. It applies noise on the load port and the mode bit only while pairs are being output, or together with `start`. Because of this, the counter and mode-stability properties describe the intended use. They do not describe the case where a load is abandoned early.

// File: rtl/sha2_sched_pkg.sv
// Package: constants and helpers shared by the schedule generator.
// Assumes words are carried at 64 bits; narrow-mode words use bits [31:0].
package sha2_sched_pkg;
    localparam int WORD_W       = 64;
    localparam int HALF_W       = WORD_W / 2;
    localparam int WIN_DEPTH    = 16;
    localparam int NARROW_PAIRS = 32;
    localparam int WIDE_PAIRS   = 40;
    localparam int PAIR_W       = $clog2(WIDE_PAIRS);
    localparam int LOAD_W       = $clog2(WIN_DEPTH);
    localparam int AMT_W        = 6;
    localparam int LUT_ADDR_W   = 5;
    localparam int AMT_COUNT    = 6;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [AMT_W-1:0]  amt_t;
    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} sched_state_t;

    // Rotate right on a full word; an amount of 0 leaves x unchanged.
    function automatic word_t rotr_wide(input word_t x, input amt_t n);
        return (x >> n) | (x << (7'(WORD_W) - {1'b0, n}));
    endfunction

    // Rotate right on the low half of a word.
    function automatic logic [HALF_W-1:0] rotr_narrow(input logic [HALF_W-1:0] x, input amt_t n);
        return (x >> n) | (x << (7'(HALF_W) - {1'b0, n}));
    endfunction

    // Keep the low half only when the narrow mode is selected.
    function automatic word_t fit_word(input word_t x, input logic wide);
        return wide ? x : {{HALF_W{1'b0}}, x[HALF_W-1:0]};
    endfunction
endpackage

// File: rtl/sched_shift_lut.sv
// Module: lookup table of rotate/shift amounts for both sigma functions.
// The address is {mode, slot}. Slot order is sigma0 rot, rot, shr, then
// sigma1 rot, rot, shr. Assumes the mode is stable while in use.
module sched_shift_lut
    import sha2_sched_pkg::*;
(
    input  logic wide,
    output amt_t amt [AMT_COUNT]
);
    // Table contents: 5-bit address, 6-bit entries.
    function automatic amt_t lut_entry(input logic [LUT_ADDR_W-1:0] addr);
        case (addr)
            5'h00: return 6'd7;
            5'h01: return 6'd18;
            5'h02: return 6'd3;
            5'h03: return 6'd17;
            5'h04: return 6'd19;
            5'h05: return 6'd10;
            5'h10: return 6'd1;
            5'h11: return 6'd8;
            5'h12: return 6'd7;
            5'h13: return 6'd19;
            5'h14: return 6'd61;
            5'h15: return 6'd6;
            default: return 6'd0;
        endcase
    endfunction

    for (genvar s = 0; s < AMT_COUNT; s++) begin : g_slot
        // Read one slot of the table for the current mode.
        assign amt[s] = lut_entry({wide, 4'(s)});
    end
endmodule

// File: rtl/sched_sigma.sv
// Module: one small-sigma function made of two rotations and one shift.
// Assumes narrow-mode inputs carry data in bits [31:0] only.
module sched_sigma
    import sha2_sched_pkg::*;
(
    input  word_t x,
    input  logic  wide,
    input  amt_t  rot_a,
    input  amt_t  rot_b,
    input  amt_t  shr_c,
    output word_t y
);
    logic [HALF_W-1:0] xn;
    logic [HALF_W-1:0] yn;
    word_t             yw;

    // Evaluate both widths and select the one the mode asks for.
    always_comb begin
        xn = x[HALF_W-1:0];
        yn = rotr_narrow(xn, rot_a) ^ rotr_narrow(xn, rot_b) ^ (xn >> shr_c);
        yw = rotr_wide(x, rot_a) ^ rotr_wide(x, rot_b) ^ (x >> shr_c);
        y  = wide ? yw : {{HALF_W{1'b0}}, yn};
    end
endmodule

// File: rtl/sched_ctrl.sv
// Module: sequencing of the schedule generator. It holds the mode,
// counts loaded words and counts output pairs. Assumes start is a pulse.
module sched_ctrl
    import sha2_sched_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide_sel,
    input  logic              in_valid,
    output logic              mode_q,
    output logic              load_take,
    output logic              advance,
    output logic              running,
    output logic [PAIR_W-1:0] pair_idx
);
    sched_state_t      state;
    logic [LOAD_W-1:0] ld_cnt;
    logic [PAIR_W-1:0] last_idx;

    // Index of the final pair for the captured mode.
    assign last_idx  = mode_q ? PAIR_W'(WIDE_PAIRS - 1) : PAIR_W'(NARROW_PAIRS - 1);
    assign running   = (state == ST_RUN);
    assign load_take = (state == ST_LOAD) && in_valid && !start;
    assign advance   = running && !start;

    // State, mode capture and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ld_cnt   <= '0;
            pair_idx <= '0;
            mode_q   <= 1'b0;
        end else if (start) begin
            state  <= ST_LOAD;
            ld_cnt <= '0;
            mode_q <= wide_sel;
        end else begin
            case (state)
                ST_LOAD: if (in_valid) begin
                    ld_cnt <= ld_cnt + 1'b1;
                    if (ld_cnt == LOAD_W'(WIN_DEPTH - 1)) begin
                        state    <= ST_RUN;
                        pair_idx <= '0;
                    end
                end
                ST_RUN: begin
                    if (pair_idx == last_idx) state <= ST_IDLE;
                    else                      pair_idx <= pair_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: a reset edge leaves the block idle.
    a_r1_idle_after_reset: assert property (@(posedge clk) !rst_n |=> !running);
    // R7: the pair counter never passes the last pair of the mode.
    a_r7_pair_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> pair_idx <= last_idx);
    // R7: after the last pair, the output phase ends.
    a_r7_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && pair_idx == last_idx) |=> !running);
    // R6: pairs follow each other with no gap.
    a_r6_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && pair_idx != last_idx) |=> (running && pair_idx == $past(pair_idx) + 1'b1));
    // R8: the mode changes only on start.
    a_r8_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(mode_q));
    // R2: no word is taken while pairs are being output.
    a_r2_no_load_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !load_take);
endmodule

// File: rtl/sha2_sched_pair.sv
// Module: top of the paired-word SHA-2 message schedule generator.
// A 16-word window shifts by one per loaded word and by two per output
// pair. The two new words depend only on the window, never on each other.
// Assumes a full block of 16 words follows every start.
module sha2_sched_pair
    import sha2_sched_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wide_sel,
    input  logic        in_valid,
    input  logic [63:0] in_word,
    output logic        pair_valid,
    output logic [6:0]  pair_base,
    output logic [63:0] word_even,
    output logic [63:0] word_odd
);
    localparam int LANES = 2;

    logic              mode_q;
    logic              load_take;
    logic              advance;
    logic              running;
    logic [PAIR_W-1:0] pair_idx;
    amt_t              amt [AMT_COUNT];
    word_t             win [WIN_DEPTH];
    word_t             fresh [LANES];

    sched_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wide_sel  (wide_sel),
        .in_valid  (in_valid),
        .mode_q    (mode_q),
        .load_take (load_take),
        .advance   (advance),
        .running   (running),
        .pair_idx  (pair_idx)
    );

    sched_shift_lut u_lut (
        .wide (mode_q),
        .amt  (amt)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        word_t s0;
        word_t s1;
        word_t sum;

        sched_sigma u_sig0 (
            .x     (win[1 + j]),
            .wide  (mode_q),
            .rot_a (amt[0]),
            .rot_b (amt[1]),
            .shr_c (amt[2]),
            .y     (s0)
        );

        sched_sigma u_sig1 (
            .x     (win[WIN_DEPTH - 2 + j]),
            .wide  (mode_q),
            .rot_a (amt[3]),
            .rot_b (amt[4]),
            .shr_c (amt[5]),
            .y     (s1)
        );

        // Add the four terms of the recurrence for word 16 + j ahead of the oldest.
        always_comb begin
            sum      = s1 + win[WIN_DEPTH - 7 + j] + s0 + win[j];
            fresh[j] = fit_word(sum, mode_q);
        end
    end

    // Window update: shift in one loaded word, or shift by two new words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_DEPTH; i++) win[i] <= '0;
        end else if (load_take) begin
            for (int i = 0; i < WIN_DEPTH - 1; i++) win[i] <= win[i + 1];
            win[WIN_DEPTH - 1] <= fit_word(in_word, mode_q);
        end else if (advance) begin
            for (int i = 0; i < WIN_DEPTH - LANES; i++) win[i] <= win[i + LANES];
            for (int j = 0; j < LANES; j++) win[WIN_DEPTH - LANES + j] <= fresh[j];
        end
    end

    // Present the two oldest words as the current pair.
    assign pair_valid = running;
    assign pair_base  = {pair_idx, 1'b0};
    assign word_even  = win[0];
    assign word_odd   = win[1];

    // R10: the upper halves of both output words are clear in narrow mode.
    a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !mode_q) |-> (word_even[63:32] == '0 && word_odd[63:32] == '0));
    // R6: an output pair moves forward by two words.
    a_r6_pair_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && pair_idx != '0) |-> (word_even == $past(win[2]) || !$past(advance)));
    // R8: the load port cannot change the window while pairs are being output.
    a_r8_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_take && !advance) |=> (win[0] == $past(win[0]) && win[15] == $past(win[15])));
endmodule

// File: tb/sha2_sched_pair_tb_top.sv
// Bench: directed scenarios. Expected schedule words come from a reference
// model of the recurrence with fixed rotate and shift amounts.
module sha2_sched_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        pair_valid;
    logic [6:0]  pair_base;
    logic [63:0] word_even;
    logic [63:0] word_odd;

    int          errors = 0;
    int          checks = 0;
    logic [63:0] blk [16];
    logic [63:0] expw [80];
    logic [63:0] lcg = 64'h0123_4567_89ab_cdef;

    always #2 clk = ~clk;

    sha2_sched_pair dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
        .in_valid(in_valid), .in_word(in_word), .pair_valid(pair_valid),
        .pair_base(pair_base), .word_even(word_even), .word_odd(word_odd)
    );

    function automatic logic [63:0] nxt(input logic [63:0] s);
        return s * 64'd6364136223846793005 + 64'd1442695040888963407;
    endfunction

    function automatic logic [31:0] r32(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    function automatic logic [63:0] r64(input logic [63:0] x, input int n);
        return (x >> n) | (x << (64 - n));
    endfunction

    function automatic logic [63:0] ref_s0(input logic [63:0] x, input logic wide);
        if (wide) return r64(x, 1) ^ r64(x, 8) ^ (x >> 7);
        return {32'd0, r32(x[31:0], 7) ^ r32(x[31:0], 18) ^ (x[31:0] >> 3)};
    endfunction

    function automatic logic [63:0] ref_s1(input logic [63:0] x, input logic wide);
        if (wide) return r64(x, 19) ^ r64(x, 61) ^ (x >> 6);
        return {32'd0, r32(x[31:0], 17) ^ r32(x[31:0], 19) ^ (x[31:0] >> 10)};
    endfunction

    task automatic build_expected(input logic wide);
        for (int t = 0; t < 80; t++) begin
            logic [63:0] v;
            if (t < 16) v = blk[t];
            else        v = ref_s1(expw[t-2], wide) + expw[t-7] + ref_s0(expw[t-15], wide) + expw[t-16];
            expw[t] = wide ? v : {32'd0, v[31:0]};
        end
    endtask

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Scenario: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {127'd0, pair_valid}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {127'd0, pair_valid}, 128'd0);
    endtask

    // Scenario: load one block and check its pairs; abort_at < npairs stops early.
    task automatic t_block(input logic wide, input logic noise, input int abort_at);
        int npairs;
        npairs = wide ? 40 : 32;
        for (int i = 0; i < 16; i++) begin
            lcg = nxt(lcg);
            blk[i] = wide ? lcg : {32'd0, lcg[31:0]};
        end
        build_expected(wide);
        // R9: in_valid with start is ignored.
        @(negedge clk);
        start = 1'b1; wide_sel = wide; in_valid = 1'b1; in_word = ~lcg;
        @(negedge clk);
        start = 1'b0;
        chk("R2", {127'd0, pair_valid}, 128'd0);
        for (int i = 0; i < 16; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 8) begin
                in_valid = 1'b0; in_word = 64'hdead_beef_dead_beef;
                @(negedge clk);
                chk("R2", {127'd0, pair_valid}, 128'd0);
            end
            in_valid = 1'b1;
            // R3: narrow mode drops the upper half of the loaded word.
            in_word = wide ? blk[i] : {~blk[i][31:0] ^ 32'h5a5a_5a5a, blk[i][31:0]};
        end
        for (int k = 0; k < npairs; k++) begin
            if (k == abort_at) return;
            @(negedge clk);
            if (noise) begin
                lcg = nxt(lcg);
                in_valid = lcg[0]; in_word = lcg; wide_sel = lcg[1];
            end else begin
                in_valid = 1'b0;
            end
            chk("R6", {120'd0, pair_valid, pair_base}, {120'd0, 1'b1, 7'(2 * k)});
            if (k < 8)      chk("R3", {word_even, word_odd}, {expw[2*k], expw[2*k+1]});
            else if (wide)  chk(noise ? "R8" : "R5", {word_even, word_odd}, {expw[2*k], expw[2*k+1]});
            else            chk(noise ? "R8" : "R4", {word_even, word_odd}, {expw[2*k], expw[2*k+1]});
            if (!wide) chk("R10", {64'd0, word_even[63:32], word_odd[63:32]}, 128'd0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7", {127'd0, pair_valid}, 128'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_block(1'b0, 1'b0, 99);
        t_block(1'b1, 1'b0, 99);
        t_block(1'b1, 1'b1, 99);
        t_block(1'b0, 1'b1, 99);
        // R9: start while pairs are being output abandons the block.
        t_block(1'b1, 1'b0, 5);
        t_block(1'b0, 1'b0, 99);
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule